// File: doc/BRIEF.md
# DRAM Refresh Scheduler

This block keeps the contents of an asynchronous-strobe DRAM alive. In normal operation it counts clock cycles and, once per row interval, raises a refresh request toward the access sequencer. The sequencer then runs a CAS-before-RAS cycle. That cycle needs no row address because the memory's internal row counter advances on its own. Requests the sequencer has not yet served add up as a debt. The debt is bounded by a parameter, and a sticky error flag records any overflow. A mode input picks between the standard interval, which spreads every row over the retention period, and a much slower battery-backup interval used on low-power parts.

For deep sleep the block takes the strobes itself. When a sleep request arrives and no refresh is outstanding, the block lowers CAS first, then RAS, and holds both low. The memory then refreshes itself. The block acknowledges the sleep while the strobes are held. It keeps them held for a minimum time even if the request is withdrawn early. To exit, it raises both strobes for a precharge period. It then insists on a burst that refreshes every row before the busy flag drops and normal traffic may continue. Mode changes are accepted only while nothing is outstanding, and they restart the interval timer.

Top module: `dram_refresh_sched`

## Requirements
- R1: During and right after reset, ref_req, ovr_en, sleep_ack, busy and debt_err are 0, and ras_ovr_n and cas_ovr_n are 1.
- R2: With mode_sel=0 (normal), the first request is counted NORM_CYC+1 clock edges after reset release, and later ones every NORM_CYC edges. ref_req is high whenever at least one counted request is unserved.
- R3: With mode_sel=1 (battery backup), requests are counted every BATT_CYC edges, measured from the edge at which that mode was taken.
- R4: A ref_ack while requests are owed retires exactly one of them. A ref_ack with none owed has no effect, and the debt never goes below zero.
- R5: The owed count saturates at DEBT_MAX. A request that arrives when DEBT_MAX are already owed, without an ack on the same edge, sets debt_err, which stays set until reset.
- R6: A change of mode_sel is taken only on an edge where no request is owed and the block is idle, and taking it restarts the interval count.
- R7: Self-refresh entry starts only from idle with nothing owed. It drives cas_ovr_n=0 with ras_ovr_n=1 for CSR_CYC cycles, then both low with sleep_ack=1. ovr_en=1 marks the strobes as owned by the block.
- R8: Both strobes stay low for at least SR_MIN_CYC cycles even if sleep_req falls earlier. After that they stay low for as long as sleep_req is held, and exit begins on the first edge that sees sleep_req low.
- R9: On exit, both strobes go high with ovr_en=1 for RP_CYC cycles, and no refresh request is raised meanwhile.
- R10: After the precharge, ref_req stays high until ROWS acks have been received. busy is high from self-refresh entry until the edge of the last of these acks.
- R11: While a request is owed, sleep_req does not start self refresh.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_sel | input | 1 | 0 = normal interval, 1 = battery-backup interval |
| sleep_req | input | 1 | Request to enter and stay in self refresh |
| ref_ack | input | 1 | Sequencer has performed one refresh cycle |
| ref_req | output | 1 | Refresh wanted from the sequencer |
| ras_ovr_n | output | 1 | RAS level driven by the block while ovr_en is high |
| cas_ovr_n | output | 1 | CAS level driven by the block while ovr_en is high |
| ovr_en | output | 1 | Block owns the strobes (entry, hold, exit) |
| sleep_ack | output | 1 | Self refresh is holding both strobes low |
| busy | output | 1 | Self-refresh sequence or post-exit burst in progress |
| debt_err | output | 1 | Sticky flag: owed requests exceeded DEBT_MAX |

## Verification
The bench builds the block with ROWS=8, NORM_CYC=20, BATT_CYC=50, CSR_CYC=2, SR_MIN_CYC=30, RP_CYC=4 and DEBT_MAX=3. With these values, debt saturation takes only four unserved intervals, and a full post-exit burst takes eight acks. Every edge of entry, minimum hold, precharge and burst can therefore be checked at its exact cycle. Both interval lengths, and a mode switch that is held back by an owed request, fit within a few hundred cycles. The small row count also lets the burst be fed random ack gaps.

// File: rtl/dram_ref_pkg.sv
`timescale 1ns/1ps
package dram_ref_pkg;

  typedef enum logic [2:0] {
    SR_IDLE  = 3'd0,
    SR_SETUP = 3'd1,
    SR_HOLD  = 3'd2,
    SR_EXIT  = 3'd3,
    SR_BURST = 3'd4
  } sr_state_e;

  typedef enum logic {
    MODE_NORMAL  = 1'b0,
    MODE_BATTERY = 1'b1
  } ref_mode_e;

endpackage

// File: rtl/ref_interval_timer.sv
`timescale 1ns/1ps
module ref_interval_timer
  import dram_ref_pkg::*;
#(
  parameter int NORM_CYC = 781,
  parameter int BATT_CYC = 6250
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      run,
  input  logic      restart,
  input  ref_mode_e mode,
  output logic      tick
);
  localparam int MAXC = (NORM_CYC > BATT_CYC) ? NORM_CYC : BATT_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] limit;

  always_comb limit = (mode == MODE_BATTERY) ? CW'(BATT_CYC - 1) : CW'(NORM_CYC - 1);

  always_ff @(posedge clk) begin
    if (rst || !run || restart) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == limit) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end

  // R2 / R3: an interval boundary is a single-cycle event
  assert_tick_single_R2: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);

endmodule

// File: rtl/ref_debt_ledger.sv
`timescale 1ns/1ps
module ref_debt_ledger #(
  parameter int DEBT_MAX = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic inc,
  input  logic ack,
  output logic pending,
  output logic overflow
);
  localparam int DW = $clog2(DEBT_MAX + 1);
  localparam logic [DW-1:0] DLIM = DW'(DEBT_MAX);

  logic [DW-1:0] debt;
  logic          dec;

  assign dec     = ack && (debt != '0);
  assign pending = (debt != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      debt     <= '0;
      overflow <= 1'b0;
    end else begin
      if (inc && !dec) begin
        if (debt == DLIM) overflow <= 1'b1;
        else              debt     <= debt + 1'b1;
      end else if (dec && !inc) begin
        debt <= debt - 1'b1;
      end
    end
  end

  assert_debt_bound_R5: assert property (@(posedge clk) disable iff (rst)
    debt <= DLIM);

  assert_err_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);

  assert_ack_retires_R4: assert property (@(posedge clk) disable iff (rst)
    (ack && pending && !inc) |=> (debt == $past(debt) - 1'b1));

  assert_no_underflow_R4: assert property (@(posedge clk) disable iff (rst)
    (!pending && !inc) |=> !pending);

endmodule

// File: rtl/sr_sequencer.sv
`timescale 1ns/1ps
module sr_sequencer
  import dram_ref_pkg::*;
#(
  parameter int ROWS       = 1024,
  parameter int CSR_CYC    = 1,
  parameter int SR_MIN_CYC = 5000,
  parameter int RP_CYC     = 6
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      sleep_req,
  input  logic      can_enter,
  input  logic      ref_ack,
  output sr_state_e state
);
  localparam int M1  = (ROWS > SR_MIN_CYC) ? ROWS : SR_MIN_CYC;
  localparam int M2  = (CSR_CYC > RP_CYC) ? CSR_CYC : RP_CYC;
  localparam int SW  = $clog2(((M1 > M2) ? M1 : M2) + 1);
  localparam int HLW = $clog2(SR_MIN_CYC + 1);
  localparam logic [SW-1:0] CSR_LAST  = SW'(CSR_CYC - 1);
  localparam logic [SW-1:0] HOLD_LAST = SW'(SR_MIN_CYC - 1);
  localparam logic [SW-1:0] RP_LAST   = SW'(RP_CYC - 1);
  localparam logic [SW-1:0] ROW_LAST  = SW'(ROWS - 1);

  logic [SW-1:0]  scnt;
  logic [HLW-1:0] hold_len;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= SR_IDLE;
      scnt  <= '0;
    end else begin
      case (state)
        SR_IDLE:
          if (sleep_req && can_enter) begin
            state <= SR_SETUP;
            scnt  <= '0;
          end
        SR_SETUP:
          if (scnt == CSR_LAST) begin
            state <= SR_HOLD;
            scnt  <= '0;
          end else scnt <= scnt + 1'b1;
        SR_HOLD:
          if (scnt != HOLD_LAST) scnt <= scnt + 1'b1;
          else if (!sleep_req) begin
            state <= SR_EXIT;
            scnt  <= '0;
          end
        SR_EXIT:
          if (scnt == RP_LAST) begin
            state <= SR_BURST;
            scnt  <= '0;
          end else scnt <= scnt + 1'b1;
        SR_BURST:
          if (ref_ack) begin
            if (scnt == ROW_LAST) begin
              state <= SR_IDLE;
              scnt  <= '0;
            end else scnt <= scnt + 1'b1;
          end
        default: begin
          state <= SR_IDLE;
          scnt  <= '0;
        end
      endcase
    end
  end

  // Independent length counter for the hold window, used only by checks
  always_ff @(posedge clk) begin
    if (rst || state != SR_HOLD) hold_len <= '0;
    else if (hold_len != HLW'(SR_MIN_CYC)) hold_len <= hold_len + 1'b1;
  end

  assert_setup_then_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (state == SR_SETUP) |=> (state == SR_SETUP || state == SR_HOLD));

  assert_hold_min_R8: assert property (@(posedge clk) disable iff (rst)
    (state == SR_HOLD) |=> (state == SR_HOLD || hold_len == HLW'(SR_MIN_CYC)));

  assert_exit_to_burst_R10: assert property (@(posedge clk) disable iff (rst)
    (state == SR_EXIT) |=> (state == SR_EXIT || state == SR_BURST));

  assert_idle_entry_R11: assert property (@(posedge clk) disable iff (rst)
    (state == SR_IDLE && !can_enter) |=> (state == SR_IDLE));

endmodule

// File: rtl/dram_refresh_sched.sv
`timescale 1ns/1ps
module dram_refresh_sched
  import dram_ref_pkg::*;
#(
  parameter int ROWS       = 1024,
  parameter int NORM_CYC   = 781,
  parameter int BATT_CYC   = 6250,
  parameter int CSR_CYC    = 1,
  parameter int SR_MIN_CYC = 5000,
  parameter int RP_CYC     = 6,
  parameter int DEBT_MAX   = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic mode_sel,
  input  logic sleep_req,
  input  logic ref_ack,
  output logic ref_req,
  output logic ras_ovr_n,
  output logic cas_ovr_n,
  output logic ovr_en,
  output logic sleep_ack,
  output logic busy,
  output logic debt_err
);
  sr_state_e state;
  ref_mode_e mode_q;
  logic      tick;
  logic      pending;
  logic      idle;
  logic      mode_chg;
  logic      can_enter;

  assign idle      = (state == SR_IDLE);
  assign can_enter = !pending && !tick;
  assign mode_chg  = idle && can_enter && (ref_mode_e'(mode_sel) != mode_q);

  always_ff @(posedge clk) begin
    if (rst)           mode_q <= MODE_NORMAL;
    else if (mode_chg) mode_q <= ref_mode_e'(mode_sel);
  end

  ref_interval_timer #(
    .NORM_CYC (NORM_CYC),
    .BATT_CYC (BATT_CYC)
  ) timer_i (
    .clk     (clk),
    .rst     (rst),
    .run     (idle),
    .restart (mode_chg),
    .mode    (mode_q),
    .tick    (tick)
  );

  ref_debt_ledger #(
    .DEBT_MAX (DEBT_MAX)
  ) ledger_i (
    .clk      (clk),
    .rst      (rst),
    .inc      (tick),
    .ack      (ref_ack && (state != SR_BURST)),
    .pending  (pending),
    .overflow (debt_err)
  );

  sr_sequencer #(
    .ROWS       (ROWS),
    .CSR_CYC    (CSR_CYC),
    .SR_MIN_CYC (SR_MIN_CYC),
    .RP_CYC     (RP_CYC)
  ) seq_i (
    .clk       (clk),
    .rst       (rst),
    .sleep_req (sleep_req),
    .can_enter (can_enter),
    .ref_ack   (ref_ack),
    .state     (state)
  );

  // Outputs decode only registered state
  assign ovr_en    = (state == SR_SETUP) || (state == SR_HOLD) || (state == SR_EXIT);
  assign cas_ovr_n = !((state == SR_SETUP) || (state == SR_HOLD));
  assign ras_ovr_n = !(state == SR_HOLD);
  assign sleep_ack = (state == SR_HOLD);
  assign busy      = !idle;
  assign ref_req   = pending || (state == SR_BURST);

  assert_cas_first_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(ras_ovr_n) |-> (!cas_ovr_n && $past(!cas_ovr_n)));

  assert_ack_strobes_R7: assert property (@(posedge clk) disable iff (rst)
    sleep_ack |-> (!ras_ovr_n && !cas_ovr_n && ovr_en));

  assert_no_req_in_sr_R9: assert property (@(posedge clk) disable iff (rst)
    ovr_en |-> !ref_req);

  assert_mode_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    (mode_q != $past(mode_q)) |-> $past(!pending && state == SR_IDLE));

endmodule

// File: tb/dram_refresh_sched_tb.sv
`timescale 1ns/1ps
module dram_refresh_sched_tb_top;
  localparam int ROWS = 8, NORM = 20, BATT = 50, CSR = 2, SRMIN = 30, RP = 4, DMAX = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_sel = 1'b0, sleep_req = 1'b0, ref_ack = 1'b0;
  logic ref_req, ras_ovr_n, cas_ovr_n, ovr_en, sleep_ack, busy, debt_err;
  int   cyc = 0;
  int   n_cmp = 0, n_bad = 0;
  bit   finished = 1'b0;

  always #10 clk = ~clk;

  always @(posedge clk) cyc <= rst ? 0 : cyc + 1;

  dram_refresh_sched #(
    .ROWS(ROWS), .NORM_CYC(NORM), .BATT_CYC(BATT), .CSR_CYC(CSR),
    .SR_MIN_CYC(SRMIN), .RP_CYC(RP), .DEBT_MAX(DMAX)
  ) dut_i (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .sleep_req(sleep_req),
    .ref_ack(ref_ack), .ref_req(ref_req), .ras_ovr_n(ras_ovr_n),
    .cas_ovr_n(cas_ovr_n), .ovr_en(ovr_en), .sleep_ack(sleep_ack),
    .busy(busy), .debt_err(debt_err)
  );

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  task automatic goto_cyc(int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic idle_outputs(string tag);
    chk({tag, " ref_req"}, ref_req, 0);
    chk({tag, " ovr_en"}, ovr_en, 0);
    chk({tag, " ras"}, ras_ovr_n, 1);
    chk({tag, " cas"}, cas_ovr_n, 1);
    chk({tag, " sleep_ack"}, sleep_ack, 0);
    chk({tag, " busy"}, busy, 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; ref_ack = 1'b0; sleep_req = 1'b0;
    repeat (3) @(negedge clk);
    idle_outputs("R1 in reset");
    chk("R1 debt_err", debt_err, 0);
    rst = 1'b0;
  endtask

  function automatic bit tick_edge(int k);
    return (k > 1) && (k % NORM == 1);
  endfunction

  initial begin
    int d, b;
    bit e, a;
    void'($urandom(32'd1234));

    // Directed: normal interval, ack, overflow, saturation
    do_reset();
    goto_cyc(NORM);     chk("R2 first req early", ref_req, 0);
    goto_cyc(NORM + 1); chk("R2 first req", ref_req, 1);
    ref_ack = 1'b1;
    goto_cyc(NORM + 2); ref_ack = 1'b0;
    chk("R4 ack retires", ref_req, 0);
    goto_cyc(2*NORM);     chk("R2 period early", ref_req, 0);
    goto_cyc(2*NORM + 1); chk("R2 period", ref_req, 1);
    goto_cyc(5*NORM);     chk("R5 no err yet", debt_err, 0);
    goto_cyc(5*NORM + 1); chk("R5 overflow err", debt_err, 1);
    ref_ack = 1'b1;
    goto_cyc(5*NORM + 4); chk("R5 saturated at max", ref_req, 0);
    goto_cyc(5*NORM + 5); ref_ack = 1'b0;
    chk("R4 extra ack ignored", ref_req, 0);
    chk("R5 err sticky", debt_err, 1);
    goto_cyc(6*NORM);     chk("R4 no underflow", ref_req, 0);
    goto_cyc(6*NORM + 1); chk("R4 next req", ref_req, 1);

    // Random ack pattern against a requirement-level debt count
    do_reset();
    d = 0; e = 1'b0;
    for (int i = 0; i < 400; i++) begin
      bit inc, dec;
      a = (($urandom % 10) < 3);
      ref_ack = a;
      inc = tick_edge(cyc + 1);
      dec = a && (d > 0);
      if (inc && !dec) begin
        if (d == DMAX) e = 1'b1; else d++;
      end else if (dec && !inc) d--;
      @(negedge clk);
      chk("R4 random debt", ref_req, (d != 0) ? 1 : 0);
      chk("R5 random err", debt_err, e ? 1 : 0);
    end
    ref_ack = 1'b0;

    // Battery interval and held-off mode switch
    mode_sel = 1'b1;
    do_reset();
    goto_cyc(BATT + 1); chk("R3 batt early", ref_req, 0);
    goto_cyc(BATT + 2); chk("R3 batt req", ref_req, 1);
    mode_sel = 1'b0;
    goto_cyc(80); ref_ack = 1'b1;
    goto_cyc(81); ref_ack = 1'b0;
    chk("R6 switch held while owed", ref_req, 0);
    goto_cyc(82 + NORM);     chk("R6 restart early", ref_req, 0);
    goto_cyc(82 + NORM + 1); chk("R6 restart interval", ref_req, 1);

    // Self refresh: blocked entry, sequence, burst
    do_reset();
    goto_cyc(NORM + 1); sleep_req = 1'b1;
    goto_cyc(NORM + 5);
    chk("R11 blocked ovr_en", ovr_en, 0);
    chk("R11 blocked busy", busy, 0);
    ref_ack = 1'b1;
    goto_cyc(NORM + 6); ref_ack = 1'b0;
    goto_cyc(NORM + 7);
    chk("R7 setup ovr_en", ovr_en, 1);
    chk("R7 setup cas", cas_ovr_n, 0);
    chk("R7 setup ras", ras_ovr_n, 1);
    chk("R7 setup busy", busy, 1);
    goto_cyc(NORM + 8); chk("R7 setup len ras", ras_ovr_n, 1);
    goto_cyc(NORM + 9);
    chk("R7 hold ras", ras_ovr_n, 0);
    chk("R7 hold cas", cas_ovr_n, 0);
    chk("R7 sleep_ack", sleep_ack, 1);
    sleep_req = 1'b0;
    goto_cyc(NORM + 9 + SRMIN - 1); chk("R8 min hold", sleep_ack, 1);
    goto_cyc(NORM + 9 + SRMIN);
    chk("R9 exit ack low", sleep_ack, 0);
    chk("R9 exit ras", ras_ovr_n, 1);
    chk("R9 exit cas", cas_ovr_n, 1);
    chk("R9 exit ovr_en", ovr_en, 1);
    goto_cyc(NORM + 9 + SRMIN + RP - 1);
    chk("R9 precharge ovr_en", ovr_en, 1);
    chk("R9 precharge no req", ref_req, 0);
    goto_cyc(NORM + 9 + SRMIN + RP);
    chk("R10 burst req", ref_req, 1);
    chk("R10 burst ovr_en", ovr_en, 0);
    for (int i = 0; i < ROWS; i++) begin
      int gap = $urandom % 4;
      for (int g = 0; g < gap; g++) goto_cyc(cyc + 1);
      chk("R10 burst req held", ref_req, 1);
      chk("R10 burst busy", busy, 1);
      ref_ack = 1'b1;
      goto_cyc(cyc + 1);
      ref_ack = 1'b0;
    end
    idle_outputs("R10 burst done");

    // Long hold beyond the minimum
    b = cyc;
    sleep_req = 1'b1;
    goto_cyc(b + 1); chk("R7 second entry cas", cas_ovr_n, 0);
    goto_cyc(b + 3); chk("R7 second ack", sleep_ack, 1);
    goto_cyc(b + 47);
    chk("R8 held past min", sleep_ack, 1);
    sleep_req = 1'b0;
    goto_cyc(b + 48);
    chk("R8 exit on drop", sleep_ack, 0);
    chk("R9 exit ovr_en 2", ovr_en, 1);
    goto_cyc(b + 52); chk("R10 burst req 2", ref_req, 1);
    ref_ack = 1'b1;
    goto_cyc(b + 59); chk("R10 busy before last", busy, 1);
    goto_cyc(b + 60); chk("R10 busy after last", busy, 0);
    ref_ack = 1'b0;

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule